// File: doc/BRIEF.md
# Dual-Write Quad-Read Register File with XOR Bank Encoding

This block is a small register file of 16 entries of 32 bits. It offers four read ports that answer combinationally, and two write ports that commit on the rising clock edge. All six ports can be used in the same cycle. The intended client is a datapath that needs several operands at once and can retire two results per cycle.

Storage is split into two banks, called left and right. Each bank is built from replicated memories. Every replica has a single write port and a single read port. The replicas of a bank share one write address and one write data word, and each replica has its own read address.

A write through the left port stores the new value XOR the right bank's current word at that address. A write through the right port stores the new value XOR the left bank's current word. A read returns the XOR of both banks at its address, which yields the last value written there.

Each bank holds five replicas: one serves the opposite bank's write-side lookup, and one serves each external read port. Two writes to the same address in one cycle are the caller's responsibility to avoid. If it happens anyway, the result is still defined: the right port wins.

Top module: `xor_regfile`

## Requirements
- R1: After reset every entry reads zero on every read port.
- R2: A left-port write (`wl_en`=1) of value V to address N, with no right-port write to N in that cycle, makes every read port addressing N return V from the next cycle on.
- R3: A right-port write (`wr_en`=1) of value V to address N makes every read port addressing N return V from the next cycle on.
- R4: If both write ports target the same address in one cycle, that address reads the right port's data afterwards.
- R5: A read of an address in the same cycle as a write to it returns the old contents.
- R6: All five replicas of a bank return identical data when given the same read address.
- R7: A write changes only its own address; every other entry keeps its value.
- R8: The four read ports are independent: each returns the contents of its own address in the same cycle, whether the addresses are equal or distinct.
- R9: With a write enable low, the data and address on that port have no effect on any entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; clears both banks |
| wl_en | input | 1 | Left write port enable |
| wl_addr | input | 4 | Left write port address |
| wl_data | input | 32 | Left write port data |
| wr_en | input | 1 | Right write port enable; wins a same-address collision |
| wr_addr | input | 4 | Right write port address |
| wr_data | input | 32 | Right write port data |
| rd_addr | input | 4x4 | Read addresses; element k drives read port k |
| rd_data | output | 4x32 | Read data; element k is the decoded word at rd_addr[k] |

## Verification
Read results are due in the same cycle as their address. The bench therefore drives addresses at the falling edge and samples a quarter period later, comparing against the reference model before it applies that cycle's writes; this is also what checks R5. A write is due one rising edge later. The reference array is updated just after the edge, with the right port winning collisions, so the next sampled read checks it. Random dual writes with four random reads run for thousands of cycles, alongside directed cases for reset, collision, disabled writes and shared read addresses.

// File: rtl/xor_regfile_pkg.sv
package xor_regfile_pkg;
    localparam int unsigned RF_ENTRIES = 16;
    localparam int unsigned RF_WIDTH   = 32;
    localparam int unsigned RF_READS   = 4;
endpackage

// File: rtl/rfx_replica.sv
module rfx_replica #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned WIDTH   = 32,
    localparam int unsigned AW     = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] store [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(ENTRIES); i++) store[i] <= '0;
        end else if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/rfx_bank.sv
module rfx_bank #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned WIDTH   = 32,
    parameter int unsigned COPIES  = 5,
    localparam int unsigned AW     = $clog2(ENTRIES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [AW-1:0]                 waddr,
    input  logic [WIDTH-1:0]              wdata,
    input  logic [COPIES-1:0][AW-1:0]     raddr,
    output logic [COPIES-1:0][WIDTH-1:0]  rdata
);
    for (genvar c = 0; c < int'(COPIES); c++) begin : g_copy
        rfx_replica #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_rep (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we),
            .waddr (waddr),
            .wdata (wdata),
            .raddr (raddr[c]),
            .rdata (rdata[c])
        );
    end

    // Replicas must stay in step: same address gives same word.
    for (genvar c = 1; c < int'(COPIES); c++) begin : g_agree
        assert_replicas_agree_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (raddr[c] == raddr[0]) |-> (rdata[c] == rdata[0]));
    end
endmodule

// File: rtl/xor_regfile.sv
module xor_regfile
    import xor_regfile_pkg::*;
#(
    parameter int unsigned ENTRIES = RF_ENTRIES,
    parameter int unsigned WIDTH   = RF_WIDTH,
    parameter int unsigned READS   = RF_READS,
    localparam int unsigned AW     = $clog2(ENTRIES),
    localparam int unsigned COPIES = READS + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wl_en,
    input  logic [AW-1:0]               wl_addr,
    input  logic [WIDTH-1:0]            wl_data,
    input  logic                        wr_en,
    input  logic [AW-1:0]               wr_addr,
    input  logic [WIDTH-1:0]            wr_data,
    input  logic [READS-1:0][AW-1:0]    rd_addr,
    output logic [READS-1:0][WIDTH-1:0] rd_data
);
    // Copy 0 of each bank is the lookup for the opposite bank's writer;
    // copies 1..READS serve the external read ports.
    logic [COPIES-1:0][AW-1:0]    l_raddr, r_raddr;
    logic [COPIES-1:0][WIDTH-1:0] l_rdata, r_rdata;
    logic [WIDTH-1:0]             l_wdata, r_wdata;
    logic                         clash;

    always_comb begin
        l_raddr[0] = wr_addr;
        r_raddr[0] = wl_addr;
        for (int k = 0; k < int'(READS); k++) begin
            l_raddr[k+1] = rd_addr[k];
            r_raddr[k+1] = rd_addr[k];
        end
    end

    // Same-address collision: left entry forced to zero, right takes raw value.
    assign clash   = wl_en && wr_en && (wl_addr == wr_addr);
    assign l_wdata = clash ? '0      : (wl_data ^ r_rdata[0]);
    assign r_wdata = clash ? wr_data : (wr_data ^ l_rdata[0]);

    rfx_bank #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .COPIES(COPIES)) u_left (
        .clk(clk), .rst_n(rst_n), .we(wl_en), .waddr(wl_addr), .wdata(l_wdata),
        .raddr(l_raddr), .rdata(l_rdata)
    );

    rfx_bank #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .COPIES(COPIES)) u_right (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_addr), .wdata(r_wdata),
        .raddr(r_raddr), .rdata(r_rdata)
    );

    for (genvar k = 0; k < int'(READS); k++) begin : g_read
        assign rd_data[k] = l_rdata[k+1] ^ r_rdata[k+1];

        assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!rst_n) |-> (rd_data[k] == '0));

        assert_left_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(wl_en && !(wr_en && wr_addr == wl_addr)) && rd_addr[k] == $past(wl_addr))
            |-> (rd_data[k] == $past(wl_data)));

        assert_right_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(wr_en) && rd_addr[k] == $past(wr_addr))
            |-> (rd_data[k] == $past(wr_data)));

        assert_clash_right_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(clash) && rd_addr[k] == $past(wr_addr))
            |-> (rd_data[k] == $past(wr_data)));
    end
endmodule

// File: tb/xor_regfile_test.sv
module xor_regfile_test;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 16;
    localparam int W   = 32;
    localparam int RD  = 4;
    localparam int AW  = 4;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     wl_en = 1'b0, wr_en = 1'b0;
    logic [AW-1:0]            wl_addr = '0, wr_addr = '0;
    logic [W-1:0]             wl_data = '0, wr_data = '0;
    logic [RD-1:0][AW-1:0]    rd_addr = '0;
    logic [RD-1:0][W-1:0]     rd_data;

    logic [W-1:0] model [N];
    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xor_regfile uut (
        .clk(clk), .rst_n(rst_n),
        .wl_en(wl_en), .wl_addr(wl_addr), .wl_data(wl_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [W-1:0] expect_at(input logic [AW-1:0] a);
        return model[a];
    endfunction

    task automatic check(input string req, input int port, input logic [W-1:0] got,
                         input logic [W-1:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s port %0d: got %h expected %h", req, port, got, exp);
        end
    endtask

    // One cycle: drive at falling edge, check reads against pre-write model,
    // then apply writes to the model after the rising edge (right port wins).
    task automatic cycle(input string req,
                         input logic le, input logic [AW-1:0] la, input logic [W-1:0] ld,
                         input logic re, input logic [AW-1:0] ra, input logic [W-1:0] rdv,
                         input logic [RD-1:0][AW-1:0] addrs);
        @(negedge clk);
        wl_en = le; wl_addr = la; wl_data = ld;
        wr_en = re; wr_addr = ra; wr_data = rdv;
        rd_addr = addrs;
        #(CLK_PERIOD/4);
        for (int k = 0; k < RD; k++) check(req, k, rd_data[k], expect_at(addrs[k]));
        @(posedge clk);
        #1;
        if (le) model[la] = ld;
        if (re) model[ra] = rdv;
    endtask

    function automatic logic [RD-1:0][AW-1:0] same4(input logic [AW-1:0] a);
        logic [RD-1:0][AW-1:0] v;
        for (int k = 0; k < RD; k++) v[k] = a;
        return v;
    endfunction

    initial begin
        logic [RD-1:0][AW-1:0] ad;
        int seed_v;
        seed_v = $urandom(32'd4242);
        for (int i = 0; i < N; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: every entry zero after reset
        for (int a = 0; a < N; a += RD) begin
            for (int k = 0; k < RD; k++) ad[k] = AW'(a + k);
            cycle("R1", 0, 0, 0, 0, 0, 0, ad);
        end

        // R2 / R3: single writes on each port, R5 read same cycle sees old
        cycle("R5", 1, 4'd3, 32'hA5A5_0001, 1, 4'd5, 32'h5A5A_0002, {4'd3, 4'd5, 4'd3, 4'd5});
        cycle("R2", 0, 0, 0, 0, 0, 0, same4(4'd3));
        cycle("R3", 0, 0, 0, 0, 0, 0, same4(4'd5));
        // R7: neighbours untouched
        cycle("R7", 0, 0, 0, 0, 0, 0, {4'd2, 4'd4, 4'd6, 4'd0});

        // Overwrite on opposite port: left bank now encodes against right
        cycle("R2", 1, 4'd5, 32'h1234_5678, 0, 0, 0, same4(4'd5));
        cycle("R2", 0, 0, 0, 1, 4'd3, 32'hDEAD_BEEF, same4(4'd5));
        cycle("R3", 0, 0, 0, 0, 0, 0, {4'd3, 4'd5, 4'd3, 4'd5});

        // R4: collision, right port wins
        cycle("R4", 1, 4'd9, 32'h1111_1111, 1, 4'd9, 32'h2222_2222, same4(4'd9));
        cycle("R4", 0, 0, 0, 0, 0, 0, same4(4'd9));
        cycle("R4", 1, 4'd9, 32'h3333_3333, 0, 0, 0, same4(4'd9));
        cycle("R4", 0, 0, 0, 0, 0, 0, same4(4'd9));

        // R9: disabled ports carry data that must not land
        cycle("R9", 0, 4'd3, 32'hFFFF_FFFF, 0, 4'd5, 32'hFFFF_FFFF, {4'd3, 4'd5, 4'd9, 4'd0});
        cycle("R9", 0, 0, 0, 0, 0, 0, {4'd3, 4'd5, 4'd9, 4'd0});

        // R8: all ports on one address, then all distinct
        cycle("R8", 0, 0, 0, 0, 0, 0, same4(4'd9));
        cycle("R8", 0, 0, 0, 0, 0, 0, {4'd15, 4'd9, 4'd5, 4'd3});

        // Random dual writes with four random reads (R6 via shared addresses)
        for (int n = 0; n < 4000; n++) begin
            for (int k = 0; k < RD; k++) ad[k] = AW'($urandom_range(0, N-1));
            cycle("R6", 1'($urandom_range(0, 1)), AW'($urandom_range(0, N-1)), $urandom(),
                        1'($urandom_range(0, 1)), AW'($urandom_range(0, N-1)), $urandom(), ad);
        end

        // Final sweep of every entry
        for (int a = 0; a < N; a += RD) begin
            for (int k = 0; k < RD; k++) ad[k] = AW'(a + k);
            cycle("R7", 0, 0, 0, 0, 0, 0, ad);
        end

        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule